// File: doc/BRIEF.md
# Masked Path-Flag Side Table

This block sits beside a content-addressable match array and supplies a second chance at a hit. It keeps a one-bit flag for each of 4096 virtual-path identifiers. On every compare, the top twelve bits of the 32-bit search word are ANDed with a configurable mask, and the result selects one flag. A flag value of zero means the path is known. The flag is then merged with the primary match result, which arrives on input ports together with the compare strobe. A primary match always wins. A table hit counts only when the table is enabled, and only when the primary array missed.

Software fills the table through a one-bit write port and can read any entry back through the same address lines. Reset leaves the table contents alone, so every entry must be written before the table is enabled. Every compare returns its result exactly one clock after the strobe. That result has two active-low flags: one for any match and one for a primary-array match. It also carries the winning address and page.

Top module: `pathflag_lookup`

## Requirements
- R1: During and after reset, `res_valid` is 0, `match_n` and `cam_match_n` are 1, and `res_addr` and `res_page` are 0. Reset does not alter stored flag values.
- R2: `res_valid` is 1 in exactly the cycle after a cycle with `cmp_valid` high. Back-to-back strobes give back-to-back results.
- R3: The lookup index is `cmp_word[31:20] & cfg_word[23:12]`. A masked-off bit is forced to 0, both for the table read and for the reported address.
- R4: A stored flag of 0 is a hit and a stored flag of 1 is a miss.
- R5: The table takes part only while `cfg_word[24]` is 1. While it is 0, a stored 0 gives no match.
- R6: When `cam_hit` is 1 at the strobe, the result has `match_n`=0 and `cam_match_n`=0, with `res_addr`=`cam_addr` and `res_page`=`cam_page`, whatever the table holds.
- R7: On an enabled table hit without `cam_hit`, the result has `match_n`=0 and `cam_match_n`=1, with `res_addr` equal to the masked index and `res_page`=`tbl_page`.
- R8: With neither hit, the result has `match_n`=1 and `cam_match_n`=1, with `res_addr`=0 and `res_page`=0.
- R9: When `tbl_wr_en` is 1, the flag at `tbl_addr` takes `tbl_wr_data` at the clock edge. When `cmp_valid` is 0, `tbl_rd_data` shows the entry at the previous cycle's `tbl_addr` one cycle later.
- R10: A compare and a write to the same entry in one cycle: the compare sees the value from before the write.
- R11: Configuration, table page and primary-match inputs are sampled at the strobe. Changes after the strobe do not affect that compare's result.
- R12: In a cycle with `res_valid` 0, the outputs show no match: both flags are 1 and the address and page are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 32 | Configuration word: bit 24 enables the table, bits 23..12 are the index mask |
| tbl_page | input | 4 | Page reported on a table-only hit |
| tbl_wr_en | input | 1 | Flag write strobe |
| tbl_addr | input | 12 | Maintenance address for writes and reads |
| tbl_wr_data | input | 1 | Flag value to write (0 = hit) |
| tbl_rd_data | output | 1 | Flag read back one cycle after the address |
| cmp_valid | input | 1 | Compare strobe |
| cmp_word | input | 32 | Search word; bits 31..20 index the table |
| cam_hit | input | 1 | Primary array matched |
| cam_addr | input | 12 | Primary match address |
| cam_page | input | 4 | Primary match page |
| res_valid | output | 1 | Result present |
| match_n | output | 1 | Active-low: primary match or enabled table hit |
| cam_match_n | output | 1 | Active-low: primary match only |
| res_addr | output | 12 | Winning address |
| res_page | output | 4 | Winning page |

## Verification
The hardest case to reach from the ports is a compare and a flag write that hit the same entry in the same cycle. Here the result must reflect the stored value from before the write. The bench therefore first fills all 4096 entries through the write port with a known pattern. It then issues a strobe and a write of the opposite value to that same index in a single cycle. A second compare follows to confirm that the new value has landed.

The bench also uses mask values that fold two different search words onto one entry. The reported address then differs from the unmasked field, which separates the masked path from the unmasked path.

// File: rtl/pathflag_pkg.sv
package pathflag_pkg;
    parameter int CMP_W    = 32;
    parameter int CFG_W    = 32;
    parameter int IDX_W    = 12;
    parameter int PAGE_W   = 4;
    parameter int IDX_LSB  = 20;
    parameter int MASK_LSB = 12;
    parameter int EN_BIT   = 24;
    localparam int DEPTH   = 1 << IDX_W;

    typedef struct packed {
        logic              valid;
        logic              cam_hit;
        logic [IDX_W-1:0]  cam_addr;
        logic [PAGE_W-1:0] cam_page;
        logic              tbl_en;
        logic [IDX_W-1:0]  tbl_idx;
        logic [PAGE_W-1:0] tbl_page;
    } stage_t;
endpackage

// File: rtl/pathflag_index.sv
module pathflag_index
    import pathflag_pkg::*;
(
    input  logic [CMP_W-1:0] cmp_word,
    input  logic [CFG_W-1:0] cfg_word,
    output logic [IDX_W-1:0] idx,
    output logic             en
);
    logic [IDX_W-1:0] field;
    logic [IDX_W-1:0] mask;

    always_comb begin
        field = cmp_word[IDX_LSB +: IDX_W];
        mask  = cfg_word[MASK_LSB +: IDX_W];
        idx   = field & mask;
        en    = cfg_word[EN_BIT];
    end
endmodule

// File: rtl/pathflag_ram.sv
module pathflag_ram #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic          wdata,
    input  logic [AW-1:0] raddr,
    output logic          rdata
);
    localparam int N = 1 << AW;

    logic [N-1:0] mem_q;
    logic         rdata_q;

    // read-before-write: the read takes the old contents on a same-edge write
    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
        rdata_q <= mem_q[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/pathflag_merge.sv
module pathflag_merge
    import pathflag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_valid,
    input  logic              cam_hit,
    input  logic [IDX_W-1:0]  cam_addr,
    input  logic [PAGE_W-1:0] cam_page,
    input  logic              tbl_en,
    input  logic [IDX_W-1:0]  tbl_idx,
    input  logic [PAGE_W-1:0] tbl_page,
    input  logic              flag_rd,
    output logic              res_valid,
    output logic              match_n,
    output logic              cam_match_n,
    output logic [IDX_W-1:0]  res_addr,
    output logic [PAGE_W-1:0] res_page
);
    stage_t st_d, st_q;
    logic   cam_win, tbl_win;

    always_comb begin
        st_d = '0;
        if (cmp_valid) begin
            st_d.valid    = 1'b1;
            st_d.cam_hit  = cam_hit;
            st_d.cam_addr = cam_addr;
            st_d.cam_page = cam_page;
            st_d.tbl_en   = tbl_en;
            st_d.tbl_idx  = tbl_idx;
            st_d.tbl_page = tbl_page;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        cam_win     = st_q.valid && st_q.cam_hit;
        tbl_win     = st_q.valid && !st_q.cam_hit && st_q.tbl_en && !flag_rd;
        res_valid   = st_q.valid;
        cam_match_n = !cam_win;
        match_n     = !(cam_win || tbl_win);
        res_addr    = '0;
        res_page    = '0;
        if (cam_win) begin
            res_addr = st_q.cam_addr;
            res_page = st_q.cam_page;
        end else if (tbl_win) begin
            res_addr = st_q.tbl_idx;
            res_page = st_q.tbl_page;
        end
    end
endmodule

// File: rtl/pathflag_lookup.sv
module pathflag_lookup
    import pathflag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic [PAGE_W-1:0] tbl_page,
    input  logic              tbl_wr_en,
    input  logic [IDX_W-1:0]  tbl_addr,
    input  logic              tbl_wr_data,
    output logic              tbl_rd_data,
    input  logic              cmp_valid,
    input  logic [CMP_W-1:0]  cmp_word,
    input  logic              cam_hit,
    input  logic [IDX_W-1:0]  cam_addr,
    input  logic [PAGE_W-1:0] cam_page,
    output logic              res_valid,
    output logic              match_n,
    output logic              cam_match_n,
    output logic [IDX_W-1:0]  res_addr,
    output logic [PAGE_W-1:0] res_page
);
    logic [IDX_W-1:0] idx;
    logic             en;
    logic [IDX_W-1:0] raddr;
    logic             flag_rd;

    pathflag_index u_index (
        .cmp_word (cmp_word),
        .cfg_word (cfg_word),
        .idx      (idx),
        .en       (en)
    );

    // the compare has the single read port; maintenance reads use it when idle
    assign raddr = cmp_valid ? idx : tbl_addr;

    pathflag_ram #(.AW(IDX_W)) u_ram (
        .clk   (clk),
        .we    (tbl_wr_en),
        .waddr (tbl_addr),
        .wdata (tbl_wr_data),
        .raddr (raddr),
        .rdata (flag_rd)
    );

    assign tbl_rd_data = flag_rd;

    pathflag_merge u_merge (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmp_valid   (cmp_valid),
        .cam_hit     (cam_hit),
        .cam_addr    (cam_addr),
        .cam_page    (cam_page),
        .tbl_en      (en),
        .tbl_idx     (idx),
        .tbl_page    (tbl_page),
        .flag_rd     (flag_rd),
        .res_valid   (res_valid),
        .match_n     (match_n),
        .cam_match_n (cam_match_n),
        .res_addr    (res_addr),
        .res_page    (res_page)
    );
endmodule

// File: rtl/pathflag_lookup_chk.sv
module pathflag_lookup_chk
    import pathflag_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [CFG_W-1:0]  cfg_word,
    input logic              cmp_valid,
    input logic              cam_hit,
    input logic [IDX_W-1:0]  cam_addr,
    input logic [PAGE_W-1:0] cam_page,
    input logic              res_valid,
    input logic              match_n,
    input logic              cam_match_n,
    input logic [IDX_W-1:0]  res_addr,
    input logic [PAGE_W-1:0] res_page
);
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |=> res_valid);

    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid |=> !res_valid);

    p_cam_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cam_hit) |=>
            (!match_n && !cam_match_n && res_addr == $past(cam_addr) && res_page == $past(cam_page)));

    p_flag_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cam_match_n |-> !match_n);

    p_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !cfg_word[EN_BIT] && !cam_hit) |=> match_n);

    p_masked_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !cam_hit) |=>
            ((res_addr & ~$past(cfg_word[MASK_LSB +: IDX_W])) == '0));

    p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (match_n && cam_match_n && res_addr == '0 && res_page == '0));
endmodule

bind pathflag_lookup pathflag_lookup_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_word    (cfg_word),
    .cmp_valid   (cmp_valid),
    .cam_hit     (cam_hit),
    .cam_addr    (cam_addr),
    .cam_page    (cam_page),
    .res_valid   (res_valid),
    .match_n     (match_n),
    .cam_match_n (cam_match_n),
    .res_addr    (res_addr),
    .res_page    (res_page)
);

// File: tb/pathflag_lookup_test.sv
`timescale 1ns/1ps
module pathflag_lookup_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_word = '0;
    logic [3:0]  tbl_page = '0;
    logic        tbl_wr_en = 1'b0;
    logic [11:0] tbl_addr = '0;
    logic        tbl_wr_data = 1'b0;
    logic        tbl_rd_data;
    logic        cmp_valid = 1'b0;
    logic [31:0] cmp_word = '0;
    logic        cam_hit = 1'b0;
    logic [11:0] cam_addr = '0;
    logic [3:0]  cam_page = '0;
    logic        res_valid, match_n, cam_match_n;
    logic [11:0] res_addr;
    logic [3:0]  res_page;

    int errors = 0;
    int checks = 0;
    bit model [4096];

    typedef struct {
        logic        m;
        logic        c;
        logic [11:0] a;
        logic [3:0]  p;
    } exp_t;
    exp_t  exp_q [$];
    string tag_q [$];

    always #10 clk = ~clk;

    pathflag_lookup uut (.*);

    function automatic logic [31:0] mkcfg(input bit en, input logic [11:0] mask);
        return {7'd0, en, mask, 12'd0};
    endfunction

    task automatic push_exp(input string tag);
        exp_t e;
        logic [11:0] idx;
        bit th;
        idx = cmp_word[31:20] & cfg_word[23:12];
        th  = cfg_word[24] && (model[idx] == 1'b0);
        if (cam_hit) begin
            e.m = 0; e.c = 0; e.a = cam_addr; e.p = cam_page;
        end else if (th) begin
            e.m = 0; e.c = 1; e.a = idx; e.p = tbl_page;
        end else begin
            e.m = 1; e.c = 1; e.a = '0; e.p = '0;
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic cmp(input logic [31:0] w, input logic [31:0] cfg, input logic [3:0] pg,
                       input bit ch, input logic [11:0] ca, input logic [3:0] cp, input string tag);
        @(negedge clk);
        tbl_wr_en = 0; cmp_valid = 1; cmp_word = w; cfg_word = cfg; tbl_page = pg;
        cam_hit = ch; cam_addr = ca; cam_page = cp;
        push_exp(tag);
    endtask

    task automatic wr(input logic [11:0] a, input bit d);
        @(negedge clk);
        cmp_valid = 0; tbl_wr_en = 1; tbl_addr = a; tbl_wr_data = d;
        model[a] = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmp_valid = 0; tbl_wr_en = 0; cam_hit = 0;
        end
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic rd_check(input logic [11:0] a, input string tag);
        @(negedge clk);
        cmp_valid = 0; tbl_wr_en = 0; tbl_addr = a;
        @(posedge clk); #5;
        check(tbl_rd_data === model[a], tag, "read-back", {31'd0, tbl_rd_data}, {31'd0, model[a]});
    endtask

    task automatic idle_check(input string tag);
        check(res_valid === 0 && match_n === 1 && cam_match_n === 1 && res_addr === 0 && res_page === 0,
              tag, "idle outputs", {res_valid, match_n, cam_match_n, 1'b0, res_addr, res_page},
              {1'b0, 1'b1, 1'b1, 1'b0, 12'd0, 4'd0});
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk); #5;
            if (rst_n && res_valid) begin
                if (exp_q.size() == 0) begin
                    check(0, "R2", "unexpected result", {31'd0, res_valid}, 32'd0);
                end else begin
                    exp_t  e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(match_n === e.m && cam_match_n === e.c && res_addr === e.a && res_page === e.p,
                          t, "result {m,c,addr,page}",
                          {14'd0, match_n, cam_match_n, res_addr, res_page},
                          {14'd0, e.m, e.c, e.a, e.p});
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #5 idle_check("R1");
        @(negedge clk); rst_n = 1;

        // fill the table: every third entry is a hit (stored 0)
        for (int i = 0; i < 4096; i++) wr(12'(i), (i % 3) != 0);
        wr(12'hA0C, 1'b0);
        wr(12'hABC, 1'b1);
        idle(2);

        rd_check(12'h003, "R9");
        rd_check(12'h004, "R9");
        idle_check("R12");

        cmp({12'h003, 20'h12345}, mkcfg(1, 12'hFFF), 4'h9, 0, 0, 0, "R7 R4 table hit");
        cmp({12'h004, 20'h0}, mkcfg(1, 12'hFFF), 4'h9, 0, 0, 0, "R8 R4 stored 1 miss");
        cmp({12'hABC, 20'h0}, mkcfg(1, 12'hF0F), 4'h5, 0, 0, 0, "R3 masked index hit");
        cmp({12'hABC, 20'h0}, mkcfg(1, 12'hFFF), 4'h5, 0, 0, 0, "R3 unmasked miss");
        cmp({12'h003, 20'h0}, mkcfg(0, 12'hFFF), 4'h9, 0, 0, 0, "R5 table disabled");
        cmp({12'h003, 20'h0}, mkcfg(1, 12'hFFF), 4'h9, 1, 12'h7E1, 4'h2, "R6 cam beats table");
        cmp({12'h004, 20'h0}, mkcfg(0, 12'hFFF), 4'h9, 1, 12'h123, 4'hC, "R6 cam alone");
        cmp({12'hFFF, 20'h0}, mkcfg(1, 12'h000), 4'h3, 0, 0, 0, "R3 all masked to entry 0");
        idle(2);
        idle_check("R12");

        // compare and same-entry write in one cycle
        @(negedge clk);
        cmp_valid = 1; cmp_word = {12'h006, 20'h0}; cfg_word = mkcfg(1, 12'hFFF);
        tbl_page = 4'h1; cam_hit = 0;
        push_exp("R10 old value seen");
        tbl_wr_en = 1; tbl_addr = 12'h006; tbl_wr_data = 1'b1;
        model[12'h006] = 1'b1;
        cmp({12'h006, 20'h0}, mkcfg(1, 12'hFFF), 4'h1, 0, 0, 0, "R10 new value after write");
        idle(2);

        // configuration change right after the strobe
        cmp({12'h009, 20'h0}, mkcfg(1, 12'hFFF), 4'hA, 0, 0, 0, "R11 sampled at strobe");
        @(negedge clk);
        cmp_valid = 0; cfg_word = '0; tbl_page = 4'h0;
        idle(2);

        // reset mid-run keeps contents
        @(negedge clk); rst_n = 0;
        @(posedge clk); #5 idle_check("R1");
        @(negedge clk); rst_n = 1;
        rd_check(12'h009, "R1 contents kept");
        rd_check(12'h006, "R9 written value");

        idle(3);
        check(exp_q.size() == 0, "R2", "results outstanding", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule